// File: doc/BRIEF.md
# Condition field mask-map writer

This block holds a 32-bit condition register split into eight 4-bit fields and updates one field per accepted operation. Two update operations are offered. The first builds a field from the least significant bit of a 64-bit integer operand: every field bit is set when its mask bit is 1 and its map bit equals that operand bit. The second copies a source field through the mask into the destination field. The copy can then merge the old destination bits and invert selected bits with the map.

Every operation takes a 4-bit mask, a 4-bit map and a merge flag. With the merge flag set, destination bits whose mask bit is 0 keep their old value. All reads of source and old destination values use the register state from before the clock edge. An operation may therefore name the same field as source and destination, reading the old value and writing the new one in a single cycle. The whole register is visible on a flat output, and one field at a time on a combinational read port.

Top module: `cond_field_writer`

## Requirements
- R1: While `rst` is high at a rising edge, all 32 condition bits become 0.
- R2: In a cycle where `op_valid` is low, no condition bit changes, whatever the other inputs are.
- R3: With `op_sel`=2'b01 and `merge`=0, the destination field becomes `mask & ~(map ^ {4{b}})`, where b is bit 0 (the least significant bit) of the integer operand. So bit i is 1 exactly when mask bit i is 1 and map bit i equals b.
- R4: The integer operand reads as zero when `ra_idx` is 0, so b is 0 regardless of `gpr_val`. Otherwise b is `gpr_val[0]`.
- R5: With `op_sel`=2'b01 and `merge`=1, the value from R3 is ORed with (old destination AND NOT mask).
- R6: With `op_sel`=2'b10 and `merge`=0, the destination field becomes `mask & src`, where src is the field selected by `src_idx`. No map inversion is applied.
- R7: With `op_sel`=2'b10 and `merge`=1, the destination becomes `((mask & src) | (old & ~mask)) ^ map`.
- R8: An operation changes only the field selected by `dst_idx`. All other fields keep their values.
- R9: When `src_idx` equals `dst_idx`, the copy uses the field value from before the edge.
- R10: `op_sel` codes 2'b00 and 2'b11 change nothing, even with `op_valid` high.
- R11: Field k appears on `cr_all[31-4k:28-4k]`, so field 0 occupies the top nibble. `rd_field` shows the current value of field `rd_idx`, combinationally.
- R12: A write is visible on `cr_all` only after the rising edge that accepts it. Before that edge the outputs still hold the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation accepted at this edge |
| op_sel | input | 2 | 01 integer-sourced, 10 field copy, others no-op |
| dst_idx | input | 3 | Destination field index |
| src_idx | input | 3 | Source field index for the copy |
| ra_idx | input | 5 | Integer register index; 0 forces the operand to zero |
| gpr_val | input | 64 | Integer operand value |
| mask | input | 4 | Per-bit mask |
| map | input | 4 | Per-bit map |
| merge | input | 1 | Keep unmasked destination bits |
| rd_idx | input | 3 | Read port field index |
| rd_field | output | 4 | Current value of field rd_idx |
| cr_all | output | 32 | Whole condition register, field 0 on top |

## Verification
Each accepted operation lands at the rising edge where `op_valid` is high. Its result is due on `cr_all` and `rd_field` one edge after the inputs are driven. The bench drives on a falling edge and samples at the next falling edge, half a period after the write. One time unit after driving, and before the edge, it also confirms that the outputs still hold the old value. Idle and no-op cycles are checked at the same half-period offset: nothing may change across them.

// File: rtl/cfw_pkg.sv
package cfw_pkg;

    localparam int FIELD_W    = 4;
    localparam int NUM_FIELDS = 8;
    localparam int FIDX_W     = $clog2(NUM_FIELDS);
    localparam int CR_W       = FIELD_W * NUM_FIELDS;
    localparam int XLEN       = 64;
    localparam int GIDX_W     = 5;

    typedef logic [FIELD_W-1:0] field_t;

    typedef enum logic [1:0] {
        OP_HOLD       = 2'b00,
        OP_FROM_INT   = 2'b01,
        OP_FROM_FIELD = 2'b10,
        OP_SPARE      = 2'b11
    } op_e;

    typedef struct packed {
        field_t mask;
        field_t map;
        logic   merge;
    } ctl_t;

    // Keep the old bits wherever the mask is clear.
    function automatic field_t keep_unmasked(field_t fresh, field_t old, field_t msk);
        return fresh | (old & ~msk);
    endfunction

    // Field 0 sits in the most significant nibble.
    function automatic field_t pick_field(logic [CR_W-1:0] cr, logic [FIDX_W-1:0] idx);
        return cr[(NUM_FIELDS-1-int'(idx))*FIELD_W +: FIELD_W];
    endfunction

endpackage

// File: rtl/cfw_int_unit.sv
module cfw_int_unit
    import cfw_pkg::*;
(
    input  logic   src_bit,
    input  ctl_t   ctl,
    input  field_t old_field,
    output field_t result
);
    field_t hits;

    always_comb begin
        hits = ctl.mask & ~(ctl.map ^ {FIELD_W{src_bit}});
        if (ctl.merge)
            result = keep_unmasked(hits, old_field, ctl.mask);
        else
            result = hits;
    end
endmodule

// File: rtl/cfw_copy_unit.sv
module cfw_copy_unit
    import cfw_pkg::*;
(
    input  field_t src_field,
    input  ctl_t   ctl,
    input  field_t old_field,
    output field_t result
);
    field_t gated;

    always_comb begin
        gated = ctl.mask & src_field;
        if (ctl.merge)
            result = keep_unmasked(gated, old_field, ctl.mask) ^ ctl.map;
        else
            result = gated;
    end
endmodule

// File: rtl/cfw_field_file.sv
module cfw_field_file #(
    parameter int NF = 8,
    parameter int FW = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [$clog2(NF)-1:0] wr_idx,
    input  logic [FW-1:0]         wr_data,
    output logic [NF*FW-1:0]      cr_flat
);
    localparam int IW = $clog2(NF);

    for (genvar k = 0; k < NF; k++) begin : g_field
        logic [FW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (wr_en && (wr_idx == IW'(k)))
                q <= wr_data;
        end
        assign cr_flat[(NF-1-k)*FW +: FW] = q;
    end
endmodule

// File: rtl/cond_field_writer.sv
module cond_field_writer
    import cfw_pkg::*;
#(
    parameter int NF    = NUM_FIELDS,
    parameter int XW    = XLEN,
    parameter int GIW   = GIDX_W,
    localparam int IW   = $clog2(NF),
    localparam int CRW  = NF * FIELD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid,
    input  logic [1:0]         op_sel,
    input  logic [IW-1:0]      dst_idx,
    input  logic [IW-1:0]      src_idx,
    input  logic [GIW-1:0]     ra_idx,
    input  logic [XW-1:0]      gpr_val,
    input  logic [FIELD_W-1:0] mask,
    input  logic [FIELD_W-1:0] map,
    input  logic               merge,
    input  logic [IW-1:0]      rd_idx,
    output logic [FIELD_W-1:0] rd_field,
    output logic [CRW-1:0]     cr_all
);
    op_e    op;
    ctl_t   ctl;
    logic   operand_lsb;
    field_t field_at [NF];
    field_t old_dst, src_val, int_res, copy_res, wr_data;
    logic   wr_en;

    assign op  = op_e'(op_sel);
    assign ctl = '{mask: mask, map: map, merge: merge};

    // Register index zero reads as a zero operand.
    assign operand_lsb = (ra_idx != '0) && gpr_val[0];

    for (genvar k = 0; k < NF; k++) begin : g_tap
        assign field_at[k] = cr_all[(NF-1-k)*FIELD_W +: FIELD_W];
    end

    assign old_dst  = field_at[dst_idx];
    assign src_val  = field_at[src_idx];
    assign rd_field = field_at[rd_idx];

    cfw_int_unit u_int (
        .src_bit  (operand_lsb),
        .ctl      (ctl),
        .old_field(old_dst),
        .result   (int_res)
    );

    cfw_copy_unit u_copy (
        .src_field(src_val),
        .ctl      (ctl),
        .old_field(old_dst),
        .result   (copy_res)
    );

    always_comb begin
        wr_en   = 1'b0;
        wr_data = old_dst;
        if (op_valid) begin
            unique case (op)
                OP_FROM_INT: begin
                    wr_en   = 1'b1;
                    wr_data = int_res;
                end
                OP_FROM_FIELD: begin
                    wr_en   = 1'b1;
                    wr_data = copy_res;
                end
                default: ;
            endcase
        end
    end

    cfw_field_file #(.NF(NF), .FW(FIELD_W)) u_file (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (dst_idx),
        .wr_data(wr_data),
        .cr_flat(cr_all)
    );
endmodule

// File: rtl/cfw_checker.sv
module cfw_checker
    import cfw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [1:0]        op_sel,
    input logic [FIDX_W-1:0] dst_idx,
    input logic [FIDX_W-1:0] src_idx,
    input logic [GIDX_W-1:0] ra_idx,
    input logic [XLEN-1:0]   gpr_val,
    input logic [3:0]        mask,
    input logic [3:0]        map,
    input logic              merge,
    input logic [CR_W-1:0]   cr_all
);
    logic            rst_seen = 1'b0;
    logic            bit_in;
    logic [CR_W-1:0] dst_window;

    assign bit_in     = (ra_idx != '0) & gpr_val[0];
    assign dst_window = {{FIELD_W{1'b1}}, {(CR_W-FIELD_W){1'b0}}} >> (FIELD_W * int'(dst_idx));

    always_ff @(posedge clk) begin
        rst_seen <= rst;
        // R1
        if (rst_seen) begin
            reset_clear_chk: assert (cr_all == '0);
        end
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(cr_all));

    // R10
    spare_code_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_sel == 2'b00 || op_sel == 2'b11)) |=> $stable(cr_all));

    // R8
    other_fields_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> (((cr_all ^ $past(cr_all)) & ~$past(dst_window)) == '0));

    // R3
    int_plain_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 2'b01 && !merge) |=>
        pick_field(cr_all, $past(dst_idx)) == $past(mask & ~(map ^ {4{bit_in}})));

    // R6
    copy_plain_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 2'b10 && !merge) |=>
        pick_field(cr_all, $past(dst_idx)) == $past(mask & pick_field(cr_all, src_idx)));

    // R7
    copy_merge_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 2'b10 && merge) |=>
        pick_field(cr_all, $past(dst_idx)) ==
        $past(((mask & pick_field(cr_all, src_idx)) | (pick_field(cr_all, dst_idx) & ~mask)) ^ map));
endmodule

bind cond_field_writer cfw_checker u_cfw_checker (
    .clk     (clk),
    .rst     (rst),
    .op_valid(op_valid),
    .op_sel  (op_sel),
    .dst_idx (dst_idx),
    .src_idx (src_idx),
    .ra_idx  (ra_idx),
    .gpr_val (gpr_val),
    .mask    (mask),
    .map     (map),
    .merge   (merge),
    .cr_all  (cr_all)
);

// File: tb/test_cond_field_writer.sv
module test_cond_field_writer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  op_sel = '0;
    logic [2:0]  dst_idx = '0, src_idx = '0, rd_idx = '0;
    logic [4:0]  ra_idx = '0;
    logic [63:0] gpr_val = '0;
    logic [3:0]  mask = '0, map = '0;
    logic        merge = 1'b0;
    logic [3:0]  rd_field;
    logic [31:0] cr_all;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [3:0] model [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_field_writer i_cond_field_writer (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .dst_idx(dst_idx), .src_idx(src_idx), .ra_idx(ra_idx), .gpr_val(gpr_val),
        .mask(mask), .map(map), .merge(merge), .rd_idx(rd_idx),
        .rd_field(rd_field), .cr_all(cr_all)
    );

    function automatic logic [31:0] packed_model();
        logic [31:0] v;
        for (int k = 0; k < 8; k++) v[31-4*k -: 4] = model[k];
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] op, input logic [2:0] d, input logic [2:0] s,
                         input logic [4:0] ra, input logic [63:0] g, input logic [3:0] m,
                         input logic [3:0] p, input logic mg, input string tag);
        logic       b;
        logic [3:0] r;
        @(negedge clk);
        op_valid = 1'b1; op_sel = op; dst_idx = d; src_idx = s; ra_idx = ra;
        gpr_val = g; mask = m; map = p; merge = mg; rd_idx = d;
        b = (ra != 0) && g[0];
        r = model[d];
        if (op == 2'b01) begin
            r = m & ~(p ^ {4{b}});
            if (mg) r = r | (model[d] & ~m);
        end else if (op == 2'b10) begin
            r = m & model[s];
            if (mg) r = (r | (model[d] & ~m)) ^ p;
        end
        #1;
        // R12: nothing visible before the accepting edge
        check("R12", cr_all, packed_model());
        model[d] = r;
        @(negedge clk);
        op_valid = 1'b0;
        check(tag, {28'b0, rd_field}, {28'b0, model[d]});
        // R8: every other field unchanged
        check("R8", cr_all, packed_model());
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) model[k] = 4'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1", cr_all, 32'h0);

        // R3 / R4 / R5: integer-sourced sweep
        for (int m = 0; m < 16; m++)
            for (int p = 0; p < 16; p++)
                for (int v = 0; v < 4; v++) begin
                    logic [4:0] ra;
                    string t;
                    ra = (v == 3) ? 5'd0 : 5'd7;
                    t = (v == 3) ? "R4" : ((v[0]) ? "R5" : "R3");
                    do_op(2'b01, 3'((m + p) % 8), 3'd0, ra,
                          {60'hABCDEF012345678, 3'b101, v[1] | (v == 3)},
                          4'(m), 4'(p), v[0], t);
                end

        // R6 / R7 / R9: field copy sweep
        for (int sv = 0; sv < 16; sv++) begin
            logic [2:0] s, d;
            s = 3'(sv % 8);
            d = sv[0] ? s : 3'((sv + 3) % 8);
            for (int m = 0; m < 16; m++)
                for (int p = 0; p < 16; p++)
                    for (int mg = 0; mg < 2; mg++) begin
                        string t;
                        // preload source with sv using an all-ones mask, operand bit 1
                        if (d != s || m == 0)
                            do_op(2'b01, s, 3'd0, 5'd1, 64'd1, 4'hF, 4'(sv), 1'b0, "R3");
                        t = (d == s) ? "R9" : (mg ? "R7" : "R6");
                        do_op(2'b10, d, s, 5'd0, 64'd0, 4'(m), 4'(p), mg[0], t);
                    end
        end

        // R10: spare codes with valid high
        for (int i = 0; i < 16; i++)
            do_op(i[0] ? 2'b11 : 2'b00, 3'(i), 3'(i + 1), 5'd3, 64'hFFFF, 4'(i), 4'(~i), i[1], "R10");

        // R2: valid low with active-looking inputs
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            op_valid = 1'b0; op_sel = 2'(i); dst_idx = 3'(i); src_idx = 3'(i + 2);
            ra_idx = 5'd9; gpr_val = 64'(i); mask = 4'hF; map = 4'(i); merge = i[0];
            @(negedge clk);
            check("R2", cr_all, packed_model());
        end

        // R11: read port and layout per field
        for (int k = 0; k < 8; k++) begin
            rd_idx = 3'(k);
            #1;
            check("R11", {28'b0, rd_field}, {28'b0, model[k]});
            check("R11", {28'b0, cr_all[31-4*k -: 4]}, {28'b0, model[k]});
        end

        // R1 again: reset from a non-zero state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 8; k++) model[k] = 4'h0;
        check("R1", cr_all, 32'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule